// File: doc/BRIEF.md
# Page Program Wraparound Collector

This block gathers the data bytes of a flash page-program command into a page-sized staging buffer. It builds a per-byte write-enable mask that the storage array applies when the command is committed. A program command begins with a start strobe that carries the byte address. The data bytes then arrive one per valid strobe. The frame is closed by an end strobe, which carries a flag saying whether the host stopped on a whole-byte boundary.

The low address bits select the first byte slot, and each later byte moves to the next slot. The slot index wraps inside the page, so a long stream overwrites the slots it filled earlier. The result is always confined to the addressed page. A frame that closes part-way through a byte cancels the whole operation. So does a frame that carried no data, or a command that the upstream checks did not allow. When the frame is good, a one-cycle commit pulse hands the page base, the buffer and the mask to the array. Because programming can only clear bits, slots that were not written hold FFh and leave the array untouched.

Top module: `pgm_page_collector`

## Requirements
- R1: On a start strobe, `page_base_o` takes the start address with its low 8 bits forced to zero. It holds that value until the next start strobe.
- R2: The first accepted data byte is stored in slot `start_addr_i[7:0]`. Each further byte goes to the following slot. Slot k occupies bits `[8k+7:8k]` of `page_data_o` and is enabled by bit k of `page_wen_o`.
- R3: After slot 255 the next byte goes to slot 0 of the same page. `page_base_o` is not changed by the wrap.
- R4: When more than 256 bytes arrive, a later byte replaces the earlier content of its slot. The committed buffer therefore holds the last 256 bytes received.
- R5: A start strobe clears every bit of `page_wen_o` and sets every slot to FFh. Afterwards only the slots that received bytes have their enable bit set; all other slots stay at FFh.
- R6: `commit_o` is high for exactly one cycle, in the cycle after a frame-end strobe. It is raised only when `frame_aligned_i` was 1, `allow_i` was 1 and at least one byte was accepted.
- R7: A frame that ends with `frame_aligned_i` = 0 produces no commit.
- R8: A frame that ends before any data byte was accepted produces no commit.
- R9: A frame whose `allow_i` is 0 at frame end produces no commit.
- R10: A byte strobed in the same cycle as the frame end is accepted and included in the commit.
- R11: After reset, `commit_o` is 0 and `page_wen_o` is all zeros.
- R12: Byte strobes received outside a command leave `page_wen_o` and `page_data_o` unchanged. This covers strobes after a frame end and before the next start, and strobes in the same cycle as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Program command begins; samples `start_addr_i` |
| start_addr_i | input | ADDR_W (24) | Byte address of the first data byte |
| allow_i | input | 1 | Command passed the upstream enable and protection checks |
| byte_vld_i | input | 1 | A received data byte is present |
| byte_i | input | 8 | Received data byte |
| frame_end_i | input | 1 | Chip select released; frame is over |
| frame_aligned_i | input | 1 | The frame ended on a whole-byte boundary |
| page_base_o | output | ADDR_W (24) | Page base address |
| page_data_o | output | 8*PAGE_BYTES (2048) | Staging buffer, slot k at bits [8k+7:8k] |
| page_wen_o | output | PAGE_BYTES (256) | Per-slot write enable |
| commit_o | output | 1 | One-cycle pulse: apply buffer and mask to the array |

## Verification
The last data byte and the frame end can fall in the same cycle. In that cycle the byte write and the commit decision compete: the byte must land in the mask, and it must also count as the byte that makes the command valid. The bench provokes this by raising `byte_vld_i` and `frame_end_i` together, both in a single-byte frame and in a longer frame. The scoreboard then expects a commit whose mask includes that final slot. A second overlap is a start strobe in the same cycle as a byte strobe; the bench checks at the ports that the stray byte leaves no trace in the new buffer.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } pgm_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pgm_offset_ctr.sv
module pgm_offset_ctr #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFF_W-1:0] load_off_i,
  input  logic             step_i,
  output logic [OFF_W-1:0] off_o
);

  logic [OFF_W-1:0] off_q, off_d;
  logic             off_en;

  always_comb begin
    off_en = load_i | step_i;
    off_d  = off_q;
    if (load_i)      off_d = load_off_i;
    else if (step_i) off_d = off_q + OFF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign off_o = off_q;

  // R3: a step from the last slot lands on slot 0
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && off_q == {OFF_W{1'b1}}) |=> (off_q == '0));

  // R2: a step advances the slot by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (off_q == $past(off_q) + OFF_W'(1)));

endmodule

// File: rtl/pgm_byte_lane.sv
module pgm_byte_lane
  import pgm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       wr_i,
  input  logic [7:0] byte_i,
  output logic [7:0] data_o,
  output logic       wen_o
);

  logic [7:0] data_q, data_d;
  logic       wen_q, wen_d;
  logic       lane_en;

  always_comb begin
    lane_en = clear_i | wr_i;
    data_d  = data_q;
    wen_d   = wen_q;
    if (clear_i) begin
      data_d = ERASED_BYTE;
      wen_d  = 1'b0;
    end else if (wr_i) begin
      data_d = byte_i;
      wen_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= ERASED_BYTE;
      wen_q  <= 1'b0;
    end else if (lane_en) begin
      data_q <= data_d;
      wen_q  <= wen_d;
    end
  end

  assign data_o = data_q;
  assign wen_o  = wen_q;

  // R5: a slot without its enable still holds the erased value
  p_unwritten_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |-> (data_q == ERASED_BYTE));

endmodule

// File: rtl/pgm_frame_ctl.sv
module pgm_frame_ctl
  import pgm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic byte_vld_i,
  input  logic frame_end_i,
  input  logic frame_aligned_i,
  input  logic allow_i,
  output logic active_o,
  output logic accept_o,
  output logic commit_o
);

  pgm_state_e state_q, state_d;
  logic       got_q, got_d;
  logic       commit_q, commit_d;
  logic       collecting;

  always_comb begin
    collecting = (state_q == ST_COLLECT);
    accept_o   = collecting && byte_vld_i && !start_i;
    state_d    = state_q;
    got_d      = got_q;
    commit_d   = 1'b0;
    if (start_i) begin
      state_d = ST_COLLECT;
      got_d   = 1'b0;
    end else if (collecting && frame_end_i) begin
      state_d  = ST_IDLE;
      got_d    = 1'b0;
      commit_d = frame_aligned_i && allow_i && (got_q || accept_o);
    end else if (accept_o) begin
      got_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      got_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      got_q    <= got_d;
      commit_q <= commit_d;
    end
  end

  assign active_o = collecting;
  assign commit_o = commit_q;

  // R6: commit is a single-cycle pulse
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R7: commit only follows an aligned frame end
  p_commit_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(frame_end_i && frame_aligned_i));

  // R9: commit only follows an allowed command
  p_commit_allowed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(allow_i));

endmodule

// File: rtl/pgm_page_collector.sv
module pgm_page_collector
  import pgm_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic                    allow_i,
  input  logic                    byte_vld_i,
  input  logic [7:0]              byte_i,
  input  logic                    frame_end_i,
  input  logic                    frame_aligned_i,
  output logic [ADDR_W-1:0]       page_base_o,
  output logic [8*PAGE_BYTES-1:0] page_data_o,
  output logic [PAGE_BYTES-1:0]   page_wen_o,
  output logic                    commit_o
);

  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  off;
  logic              active;
  logic              accept;

  // page base register
  always_comb begin
    base_d = {start_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (start_i) base_q <= base_d;
  end

  assign page_base_o = base_q;

  pgm_frame_ctl u_ctl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .byte_vld_i      (byte_vld_i),
    .frame_end_i     (frame_end_i),
    .frame_aligned_i (frame_aligned_i),
    .allow_i         (allow_i),
    .active_o        (active),
    .accept_o        (accept),
    .commit_o        (commit_o)
  );

  pgm_offset_ctr #(.OFF_W(OFF_W)) u_off (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .load_off_i (start_addr_i[OFF_W-1:0]),
    .step_i     (accept),
    .off_o      (off)
  );

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_lane
    logic lane_wr;
    assign lane_wr = accept && (off == OFF_W'(k));
    pgm_byte_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .wr_i    (lane_wr),
      .byte_i  (byte_i),
      .data_o  (page_data_o[8*k +: 8]),
      .wen_o   (page_wen_o[k])
    );
  end

  // R5: a start strobe leaves an empty mask behind
  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (page_wen_o == '0));

  // R8: a commit always carries at least one enabled slot
  p_commit_has_bytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (page_wen_o != '0));

  // R12: outside a command the buffer does not move
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_i) |=> ($stable(page_wen_o) && $stable(page_data_o)));

  // R1: the base only changes on a start strobe
  p_base_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(page_base_o));

endmodule

// File: tb/test_pgm_page_collector.sv
module test_pgm_page_collector;

  localparam int AW = 24;
  localparam int PB = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, allow_i, byte_vld_i, frame_end_i, frame_aligned_i;
  logic [AW-1:0] start_addr_i;
  logic [7:0]    byte_i;
  logic [AW-1:0] page_base_o;
  logic [8*PB-1:0] page_data_o;
  logic [PB-1:0] page_wen_o;
  logic          commit_o;

  always #4 clk = ~clk;   // 125 MHz

  pgm_page_collector i_pgm_page_collector (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .allow_i(allow_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .frame_end_i(frame_end_i), .frame_aligned_i(frame_aligned_i),
    .page_base_o(page_base_o), .page_data_o(page_data_o),
    .page_wen_o(page_wen_o), .commit_o(commit_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // scoreboard queues
  logic [AW-1:0]   q_base [$];
  logic [PB-1:0]   q_mask [$];
  logic [8*PB-1:0] q_data [$];

  // expected buffer of the most recent frame
  logic [AW-1:0]   e_base;
  logic [PB-1:0]   e_mask;
  logic [8*PB-1:0] e_data;

  // behavioural array: four pages
  logic [7:0] mem [0:4*PB-1];

  task automatic chk(input bit ok, input string tag, input logic [8*PB-1:0] act,
                     input logic [8*PB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + (i >> 8) * 5) & 8'hFE);
  endfunction

  // driver: runs one program frame and records the expected commit
  task automatic prog(input logic [AW-1:0] a, input int n, input bit allow,
                      input bit aligned, input bit merge_end, input int seed);
    bit exp_commit;
    @(negedge clk);
    start_i      = 1'b1;
    start_addr_i = a;
    allow_i      = allow;
    byte_vld_i   = 1'b1;          // stray byte with start (R12)
    byte_i       = 8'h00;
    e_base = {a[AW-1:8], 8'h00};
    e_mask = '0;
    e_data = '1;
    @(negedge clk);
    start_i    = 1'b0;
    byte_vld_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      int off;
      off = (int'(a[7:0]) + i) % PB;
      byte_vld_i = 1'b1;
      byte_i     = pat(seed, i);
      e_mask[off] = 1'b1;
      e_data[off*8 +: 8] = pat(seed, i);
      if (merge_end && i == n - 1) begin
        frame_end_i     = 1'b1;
        frame_aligned_i = aligned;
      end
      if (!(merge_end && i == n - 1)) @(negedge clk);
    end
    exp_commit = aligned && allow && (n > 0);
    if (exp_commit) begin
      q_base.push_back(e_base);
      q_mask.push_back(e_mask);
      q_data.push_back(e_data);
    end
    if (!merge_end) begin
      byte_vld_i      = 1'b0;
      frame_end_i     = 1'b1;
      frame_aligned_i = aligned;
    end
    @(negedge clk);
    byte_vld_i  = 1'b0;
    frame_end_i = 1'b0;
    chk(commit_o == exp_commit, "R6/R7/R8/R9 commit after frame end",
        {2047'b0, commit_o}, {2047'b0, exp_commit});
    @(negedge clk);
    chk(commit_o == 1'b0, "R6 commit lasts one cycle", {2047'b0, commit_o}, '0);
  endtask

  // monitor: pops expected commits and updates the array
  always @(negedge clk) begin
    if (rst_n && commit_o) begin
      if (q_base.size() == 0) begin
        chk(1'b0, "R6 unexpected commit", '0, '0);
      end else begin
        logic [AW-1:0]   xb;
        logic [PB-1:0]   xm;
        logic [8*PB-1:0] xd;
        xb = q_base.pop_front();
        xm = q_mask.pop_front();
        xd = q_data.pop_front();
        chk(page_base_o == xb, "R1 page base", {2024'b0, page_base_o}, {2024'b0, xb});
        chk(page_wen_o == xm, "R2/R3/R5 write mask", {1792'b0, page_wen_o}, {1792'b0, xm});
        chk(page_data_o == xd, "R2/R3/R4/R5 page data", page_data_o, xd);
        for (int k = 0; k < PB; k++)
          if (page_wen_o[k])
            mem[(int'(page_base_o[9:0]) + k) % (4*PB)] &= page_data_o[8*k +: 8];
      end
    end
  end

  task automatic finish_run;
    chk(q_base.size() == 0, "R6 missing commit", q_base.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4*PB; k++) mem[k] = 8'hFF;
    rst_n = 1'b0;
    start_i = 0; allow_i = 0; byte_vld_i = 0; frame_end_i = 0;
    frame_aligned_i = 0; start_addr_i = '0; byte_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(commit_o == 1'b0, "R11 commit low in reset", {2047'b0, commit_o}, '0);
    chk(page_wen_o == '0, "R11 mask clear in reset", {1792'b0, page_wen_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2, R5: short frame inside page 0
    prog(24'h000010, 4, 1'b1, 1'b1, 1'b0, 1);
    chk(page_wen_o == e_mask, "R5 only written slots enabled", {1792'b0, page_wen_o}, {1792'b0, e_mask});

    // R12: stray bytes between frames leave the buffer untouched
    @(negedge clk);
    byte_vld_i = 1'b1; byte_i = 8'h00;
    repeat (3) @(negedge clk);
    byte_vld_i = 1'b0;
    @(negedge clk);
    chk(page_wen_o == e_mask, "R12 mask unchanged by idle bytes", {1792'b0, page_wen_o}, {1792'b0, e_mask});
    chk(page_data_o == e_data, "R12 data unchanged by idle bytes", page_data_o, e_data);

    // second program over the same slots: array only loses bits
    prog(24'h000010, 2, 1'b1, 1'b1, 1'b0, 2);
    chk(mem[16] == (pat(1, 0) & pat(2, 0)), "R5 array and of two programs",
        {2040'b0, mem[16]}, {2040'b0, pat(1, 0) & pat(2, 0)});
    chk(mem[19] == pat(1, 3), "R5 untouched slot keeps earlier value",
        {2040'b0, mem[19]}, {2040'b0, pat(1, 3)});
    chk(mem[20] == 8'hFF, "R5 slot never written stays erased",
        {2040'b0, mem[20]}, {2040'b0, 8'hFF});

    // R3: wrap at end of page 1
    prog(24'h1231FE, 5, 1'b1, 1'b1, 1'b0, 3);
    chk(mem[256] == pat(3, 2), "R3 wrapped byte lands in slot 0",
        {2040'b0, mem[256]}, {2040'b0, pat(3, 2)});
    chk(mem[512] == 8'hFF, "R3 next page untouched", {2040'b0, mem[512]}, {2040'b0, 8'hFF});

    // R4: 300 bytes into page 2, last 256 survive
    prog(24'h000280, 300, 1'b1, 1'b1, 1'b0, 4);
    chk(mem[512 + 128] == pat(4, 256), "R4 overwritten slot holds later byte",
        {2040'b0, mem[640]}, {2040'b0, pat(4, 256)});

    // R7: frame ends mid-byte
    prog(24'h000300, 3, 1'b1, 1'b0, 1'b0, 5);
    chk(mem[768] == 8'hFF, "R7 no array change", {2040'b0, mem[768]}, {2040'b0, 8'hFF});
    // R8: no data byte
    prog(24'h000300, 0, 1'b1, 1'b1, 1'b0, 6);
    // R9: not allowed
    prog(24'h000300, 3, 1'b0, 1'b1, 1'b0, 7);
    chk(mem[768] == 8'hFF, "R9 no array change", {2040'b0, mem[768]}, {2040'b0, 8'hFF});

    // R10: byte together with frame end, single and multi byte
    prog(24'h000305, 1, 1'b1, 1'b1, 1'b1, 8);
    chk(mem[773] == pat(8, 0), "R10 single byte with frame end",
        {2040'b0, mem[773]}, {2040'b0, pat(8, 0)});
    prog(24'h000340, 6, 1'b1, 1'b1, 1'b1, 9);
    chk(mem[768 + 64 + 5] == pat(9, 5), "R10 last byte with frame end",
        {2040'b0, mem[837]}, {2040'b0, pat(9, 5)});

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule